// File: doc/BRIEF.md
# Sprite Graphics Register Loader

This block holds the bitmap bytes that the sprite shifters draw: four 8-bit player registers and one 8-bit missile register made of four 2-bit fields. It fills them by snooping a shared data bus. It does not know whether a sprite fetch really took place. It loads a register whenever bus snooping is granted for that object class and the active-low halt line is low during that object's slot strobe. As a result, any byte present on the bus in such a cycle lands in the sprite. This can be a display-list byte fetched in a borrowed slot, or a processor opcode held on the bus during a wait. When no halt occurs on a line, nothing reloads and the sprites repeat their old data.

A per-object vertical-delay bit suppresses bus reloads on even scanlines, which halves the vertical resolution of that object. The processor can also write any register directly through a small write port. A direct write does not depend on halt or slot timing.

Each register's next value comes from a three-way source selector: hold, bus capture or processor write. There are no further control states. Each bus capture appears on the outputs one clock after the capture cycle.

Top module: `sprite_gfx_loader`

## Requirements
- R1: While `rst_n` is low, every bit of `player_gfx` and `missile_gfx` reads zero.
- R2: When `grant_ctl[1]` is 1, `halt_n` is 0 and `slot_player[i]` is 1, player i (`player_gfx[8i+7:8i]`) takes the whole bus byte at that clock edge, whatever its value, unless R6 suppresses the load.
- R3: When `grant_ctl[0]` is 1, `halt_n` is 0 and `slot_missile` is 1, missile field i (`missile_gfx[2i+1:2i]`) takes bus bits `[2i+1:2i]` at that edge, unless R6 suppresses the load.
- R4: While `halt_n` is 1, no register changes from the bus, whatever the slot strobes, grant and bus carry.
- R5: Grant bit 1 gates only the players and grant bit 0 gates only the missiles. A class whose bit is 0 keeps its contents in its own slots.
- R6: `vdelay[4+i]` (player i) and `vdelay[i]` (missile i) block that object's bus reload while `line_odd` is 0. While `line_odd` is 1 the reload goes ahead.
- R7: A write with `cpu_we`=1 loads `cpu_wdata` into player `cpu_sel` for selects 0 to 3, or into the whole missile register for select 4, regardless of halt. Selects 5 to 7 change nothing.
- R8: If a processor write and a bus capture target the same register in the same cycle, the processor value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 8 | Shared data bus being snooped |
| halt_n | input | 1 | Active-low halt from the display fetcher |
| slot_missile | input | 1 | Strobe marking the missile slot cycle |
| slot_player | input | 4 | Strobes marking each player's slot cycle |
| line_odd | input | 1 | Scanline parity, 1 on odd lines |
| grant_ctl | input | 2 | Bit 0 missile snoop enable, bit 1 player snoop enable |
| vdelay | input | 8 | Vertical delay, missiles in [3:0], players in [7:4] |
| cpu_we | input | 1 | Processor write strobe |
| cpu_sel | input | 3 | Register select: 0 to 3 players, 4 missiles |
| cpu_wdata | input | 8 | Processor write data |
| player_gfx | output | 32 | Player registers, player i in bits [8i+7:8i] |
| missile_gfx | output | 8 | Missile register, missile i in bits [2i+1:2i] |

## Verification
The bench checks that a slot strobe with halt high leaves every register frozen. A loader keyed on the strobe alone would reload there. It checks each grant bit alone, so a swapped or shared enable shows up as the wrong class loading. Missile captures use the asymmetric byte 0xE4, so a mis-sliced field gives a visibly wrong pattern. Vertical delay is tested on both line parities, and a same-cycle collision between a processor write and a bus capture catches a design that lets the bus win.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
    localparam int NUM_PLAYERS  = 4;
    localparam int NUM_MISSILES = 4;
    localparam int GFX_W        = 8;
    localparam int MIS_FIELD_W  = GFX_W / NUM_MISSILES;
    localparam int SEL_W        = 3;
    localparam int SEL_MISSILE  = NUM_PLAYERS;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_BUS  = 2'd1,
        SRC_CPU  = 2'd2
    } load_src_e;
endpackage

// File: rtl/sgl_capture_gate.sv
module sgl_capture_gate
    import sgl_pkg::*;
(
    input  logic                    halt_n,
    input  logic                    slot_missile,
    input  logic [NUM_PLAYERS-1:0]  slot_player,
    input  logic                    line_odd,
    input  logic [1:0]              grant_ctl,
    input  logic [NUM_MISSILES+NUM_PLAYERS-1:0] vdelay,
    output logic [NUM_PLAYERS-1:0]  ld_player,
    output logic [NUM_MISSILES-1:0] ld_missile
);
    logic snoop_now;
    assign snoop_now = !halt_n;

    for (genvar p = 0; p < NUM_PLAYERS; p++) begin : g_pl
        logic skip_line;
        assign skip_line    = vdelay[NUM_MISSILES+p] && !line_odd;
        assign ld_player[p] = grant_ctl[1] && snoop_now && slot_player[p] && !skip_line;
    end

    for (genvar m = 0; m < NUM_MISSILES; m++) begin : g_ms
        logic skip_line;
        assign skip_line     = vdelay[m] && !line_odd;
        assign ld_missile[m] = grant_ctl[0] && snoop_now && slot_missile && !skip_line;
    end
endmodule

// File: rtl/sgl_gfx_reg.sv
module sgl_gfx_reg
    import sgl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_ld,
    input  logic [W-1:0] cpu_d,
    input  logic         bus_ld,
    input  logic [W-1:0] bus_d,
    output logic [W-1:0] q
);
    load_src_e src;

    always_comb begin
        if (cpu_ld)      src = SRC_CPU;
        else if (bus_ld) src = SRC_BUS;
        else             src = SRC_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case (src)
                SRC_CPU:  q <= cpu_d;
                SRC_BUS:  q <= bus_d;
                default:  q <= q;
            endcase
        end
    end

    a_r8_cpu_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ld |=> q == $past(cpu_d));
    a_r2_bus_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ld && !cpu_ld) |=> q == $past(bus_d));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ld && !cpu_ld) |=> $stable(q));
endmodule

// File: rtl/sprite_gfx_loader.sv
module sprite_gfx_loader
    import sgl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [GFX_W-1:0]                  bus_data,
    input  logic                              halt_n,
    input  logic                              slot_missile,
    input  logic [NUM_PLAYERS-1:0]            slot_player,
    input  logic                              line_odd,
    input  logic [1:0]                        grant_ctl,
    input  logic [NUM_MISSILES+NUM_PLAYERS-1:0] vdelay,
    input  logic                              cpu_we,
    input  logic [SEL_W-1:0]                  cpu_sel,
    input  logic [GFX_W-1:0]                  cpu_wdata,
    output logic [NUM_PLAYERS*GFX_W-1:0]      player_gfx,
    output logic [GFX_W-1:0]                  missile_gfx
);
    logic [NUM_PLAYERS-1:0]  ld_player;
    logic [NUM_MISSILES-1:0] ld_missile;
    logic                    cpu_mis;

    sgl_capture_gate u_gate (
        .halt_n      (halt_n),
        .slot_missile(slot_missile),
        .slot_player (slot_player),
        .line_odd    (line_odd),
        .grant_ctl   (grant_ctl),
        .vdelay      (vdelay),
        .ld_player   (ld_player),
        .ld_missile  (ld_missile)
    );

    for (genvar p = 0; p < NUM_PLAYERS; p++) begin : g_player
        logic cpu_hit;
        assign cpu_hit = cpu_we && (cpu_sel == SEL_W'(p));
        sgl_gfx_reg #(.W(GFX_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .cpu_ld(cpu_hit),
            .cpu_d (cpu_wdata),
            .bus_ld(ld_player[p]),
            .bus_d (bus_data),
            .q     (player_gfx[p*GFX_W +: GFX_W])
        );
    end

    assign cpu_mis = cpu_we && (cpu_sel == SEL_W'(SEL_MISSILE));

    for (genvar m = 0; m < NUM_MISSILES; m++) begin : g_missile
        sgl_gfx_reg #(.W(MIS_FIELD_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .cpu_ld(cpu_mis),
            .cpu_d (cpu_wdata[m*MIS_FIELD_W +: MIS_FIELD_W]),
            .bus_ld(ld_missile[m]),
            .bus_d (bus_data[m*MIS_FIELD_W +: MIS_FIELD_W]),
            .q     (missile_gfx[m*MIS_FIELD_W +: MIS_FIELD_W])
        );
    end

    a_r4_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_n && !cpu_we) |=> ($stable(player_gfx) && $stable(missile_gfx)));
    a_r5_player_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_ctl[1] && !cpu_we) |=> $stable(player_gfx));
    a_r5_missile_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_ctl[0] && !cpu_we) |=> $stable(missile_gfx));
    a_r6_vdelay_p0: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_odd && vdelay[NUM_MISSILES] && !cpu_we) |=> $stable(player_gfx[GFX_W-1:0]));
    a_r7_cpu_missile: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_mis |=> missile_gfx == $past(cpu_wdata));
    a_r3_missile_field0: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_ctl[0] && !halt_n && slot_missile && line_odd && !cpu_we)
        |=> missile_gfx[1:0] == $past(bus_data[1:0]));
endmodule

// File: tb/sprite_gfx_loader_tb_top.sv
module sprite_gfx_loader_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [7:0]  bus_data = 0;
    logic        halt_n = 1;
    logic        slot_missile = 0;
    logic [3:0]  slot_player = 0;
    logic        line_odd = 1;
    logic [1:0]  grant_ctl = 0;
    logic [7:0]  vdelay = 0;
    logic        cpu_we = 0;
    logic [2:0]  cpu_sel = 0;
    logic [7:0]  cpu_wdata = 0;
    logic [31:0] player_gfx;
    logic [7:0]  missile_gfx;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_p [4];
    logic [7:0] exp_m;

    always #2 clk = ~clk;

    sprite_gfx_loader dut_i (.*);

    task automatic check(string req, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [39:0] pack_exp();
        return {exp_m, exp_p[3], exp_p[2], exp_p[1], exp_p[0]};
    endfunction

    // reference update for the inputs currently driven, applied at the next edge
    task automatic model_step();
        for (int i = 0; i < 4; i++) begin
            if (cpu_we && cpu_sel == 3'(i)) exp_p[i] = cpu_wdata;
            else if (grant_ctl[1] && !halt_n && slot_player[i] && (line_odd || !vdelay[4+i]))
                exp_p[i] = bus_data;
        end
        for (int m = 0; m < 4; m++) begin
            if (cpu_we && cpu_sel == 3'd4) exp_m[2*m +: 2] = cpu_wdata[2*m +: 2];
            else if (grant_ctl[0] && !halt_n && slot_missile && (line_odd || !vdelay[m]))
                exp_m[2*m +: 2] = bus_data[2*m +: 2];
        end
    endtask

    task automatic idle();
        halt_n = 1; slot_missile = 0; slot_player = 0; cpu_we = 0;
    endtask

    task automatic step_and_check(string req);
        model_step();
        @(negedge clk);
        check(req, {missile_gfx, player_gfx}, pack_exp());
        idle();
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) exp_p[i] = 0;
        exp_m = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {missile_gfx, player_gfx}, 40'h0);
        rst_n = 1;
        @(negedge clk);

        // R2: player 2 capture, opcode-like byte
        grant_ctl = 2'b11; halt_n = 0; slot_player = 4'b0100; bus_data = 8'h8C;
        step_and_check("R2");
        // R3: missile field slicing
        grant_ctl = 2'b11; halt_n = 0; slot_missile = 1; bus_data = 8'hE4;
        step_and_check("R3");
        // R4: halt high, all strobes active
        grant_ctl = 2'b11; halt_n = 1; slot_missile = 1; slot_player = 4'hF; bus_data = 8'h5A;
        step_and_check("R4");
        // R5: only missiles granted, player slot must not load
        grant_ctl = 2'b01; halt_n = 0; slot_player = 4'b0001; bus_data = 8'h33;
        step_and_check("R5");
        // R5: only players granted, missile slot must not load
        grant_ctl = 2'b10; halt_n = 0; slot_missile = 1; bus_data = 8'h1F;
        step_and_check("R5");
        // R6: vdelay on player 1 and missile 3, even line: skipped
        grant_ctl = 2'b11; vdelay = 8'h28; line_odd = 0; halt_n = 0;
        slot_player = 4'b0010; bus_data = 8'hC3;
        step_and_check("R6");
        grant_ctl = 2'b11; halt_n = 0; slot_missile = 1; bus_data = 8'hFF;
        step_and_check("R6");
        // R6: odd line loads despite vdelay
        line_odd = 1; halt_n = 0; slot_player = 4'b0010; bus_data = 8'h96;
        step_and_check("R6");
        vdelay = 0;
        // R7: direct write ignores halt
        cpu_we = 1; cpu_sel = 3'd3; cpu_wdata = 8'hA7;
        step_and_check("R7");
        cpu_we = 1; cpu_sel = 3'd4; cpu_wdata = 8'h6C;
        step_and_check("R7");
        // R7: unused select changes nothing
        cpu_we = 1; cpu_sel = 3'd6; cpu_wdata = 8'hEE;
        step_and_check("R7");
        // R8: collision on player 0 and on missiles
        grant_ctl = 2'b11; halt_n = 0; slot_player = 4'b0001; bus_data = 8'h11;
        cpu_we = 1; cpu_sel = 3'd0; cpu_wdata = 8'h99;
        step_and_check("R8");
        halt_n = 0; slot_missile = 1; bus_data = 8'h00;
        cpu_we = 1; cpu_sel = 3'd4; cpu_wdata = 8'hB1;
        step_and_check("R8");

        // constrained random mix (R2 to R8 rules via model)
        void'($urandom(32'h5EED));
        for (int n = 0; n < 3000; n++) begin
            bus_data     = 8'($urandom);
            halt_n       = ($urandom % 3) != 0;
            slot_missile = ($urandom % 4) == 0;
            slot_player  = 4'(1 << ($urandom % 6));
            line_odd     = 1'($urandom);
            grant_ctl    = 2'($urandom);
            vdelay       = 8'($urandom);
            cpu_we       = ($urandom % 8) == 0;
            cpu_sel      = 3'($urandom);
            cpu_wdata    = 8'($urandom);
            step_and_check("R2");
        end

        // R1: reset mid-run clears everything
        rst_n = 0;
        @(negedge clk);
        check("R1", {missile_gfx, player_gfx}, 40'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule